// File: doc/BRIEF.md
# High-Speed Burst Sequencer for a Serial Display Data Lane

This block is the transmit-side controller for one differential data lane. It runs on the lane's byte clock. When a burst is requested it steps the lane out of the low-power stop state, through the request and bridge states, into high-speed mode. It sends a run of zero bits, then a sync byte, then the payload bytes. After the final byte it drives a trailer and returns the lane to the stop state. Each of these phases lasts a number of byte clocks taken from a packed byte-wide field in one of two 32-bit timing words.

At a 432 Mbit/s lane rate one byte clock is about 18.5 ns. The prepare time plus the zero time is the interval the receiver uses to settle. A short total in that interval is the known cause of receivers that miss the start of a burst. For this reason no phase can be cut short, skipped or reduced to zero length, whatever the request and data signals do. The timing words are captured while the lane is idle, and they stay fixed for the whole burst.

The serializer and the analog drivers lie outside this block. It presents a two-wire low-power drive pair (dp, dn), a high-speed enable and one byte per clock for the serializer.

Top module: `dphy_burst_seq`

## Requirements
- R1: After reset the lane shows stop state (dp=1, dn=1), hs_en=0, hs_data=0x00 and tx_ready=0.
- R2: Word A holds the request-state length in bits [15:8] and the exit length in bits [7:0]. Word B holds the trailer length in bits [23:16], the zero length in bits [15:8] and the prepare length in bits [7:0]. All other bits have no effect.
- R3: A tx_req seen high in an idle cycle causes, from the next cycle on, dp=0/dn=1 for the request length, then dp=0/dn=0 with hs_en=0 for the prepare length, then hs_en=1 with hs_data=0x00 for the zero length.
- R4: The cycle after the zero phase carries the sync byte 0xB8 with hs_en=1, and tx_ready goes high in that same cycle.
- R5: A byte accepted (tx_valid and tx_ready both high) appears on hs_data in the next cycle. Bytes appear in the order they were accepted. The byte accepted with tx_last is followed by one cycle in which it is shown with tx_ready=0.
- R6: Next comes the trailer. For the trailer length, hs_en=1 and every bit of hs_data is the inverse of bit 7 of the last byte, which is the last bit sent on the wire.
- R7: The lane then returns to stop state with hs_en=0 and hs_data=0x00 for at least the exit length. A tx_req that is high in those cycles does not start a burst until the idle cycle that follows.
- R8: A length field of zero gives a phase of one byte clock.
- R9: Timing words are captured in the idle cycle that accepts the request. Changes made later do not alter that burst.
- R10: Once a burst has started, tx_req has no effect on the burst. Dropping tx_req during the entry phases does not shorten or cancel any phase.
- R11: A payload cycle with tx_ready high and tx_valid low repeats the previous byte on hs_data, and the burst goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_req_i | input | 1 | Burst request, sampled while idle |
| tx_valid_i | input | 1 | Payload byte valid |
| tx_data_i | input | 8 | Payload byte |
| tx_last_i | input | 1 | Marks the final payload byte |
| tx_ready_o | output | 1 | Payload byte accepted this cycle when valid |
| cfg_a_i | input | 32 | Timing word A (request and exit lengths) |
| cfg_b_i | input | 32 | Timing word B (trailer, zero and prepare lengths) |
| lp_dp_o | output | 1 | Low-power drive, positive wire |
| lp_dn_o | output | 1 | Low-power drive, negative wire |
| hs_en_o | output | 1 | High-speed driver enable |
| hs_data_o | output | 8 | Byte handed to the serializer |

## Verification
The line states and tx_ready follow the registered phase. They change in the cycle right after the edge that moves the phase, so a request accepted at one edge shows dp=0/dn=1 from the next cycle on. hs_data is registered, so a byte accepted at an edge is on the output in the following cycle. The trailer value appears one cycle after the final byte is shown.

The bench builds the full expected trace for a burst, one entry per cycle, from the timing words and the payload it will drive. It compares lp, hs_en, hs_data and tx_ready against that trace at every falling edge, which is half a cycle after each change. It then drives the next inputs.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_RQST,
      PH_BRDG,
      PH_ZERO,
      PH_SYNC,
      PH_DATA,
      PH_TAIL,
      PH_TRAIL,
      PH_EXIT
   } phase_e;

   // low-power line pair encodings {dp, dn}
   localparam logic [1:0] LP_STOP = 2'b11;
   localparam logic [1:0] LP_RQST = 2'b01;
   localparam logic [1:0] LP_BRDG = 2'b00;

   function automatic logic lp_pos(input logic [1:0] lp);
      return lp[1];
   endfunction

   function automatic logic lp_neg(input logic [1:0] lp);
      return lp[0];
   endfunction

endpackage

// File: rtl/dphy_timing_capture.sv
module dphy_timing_capture #(
   parameter int FIELD_W   = 8,
   parameter int WORD_W    = 32,
   parameter int MIN_PHASE = 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               capture_i,
   input  logic [WORD_W-1:0]  word_a_i,
   input  logic [WORD_W-1:0]  word_b_i,
   output logic [FIELD_W-1:0] rqst_len_o,
   output logic [FIELD_W-1:0] exit_len_o,
   output logic [FIELD_W-1:0] prep_len_o,
   output logic [FIELD_W-1:0] zero_len_o,
   output logic [FIELD_W-1:0] trail_len_o
);

   localparam int NUM_FIELDS = 5;
   localparam logic [FIELD_W-1:0] FLOOR = FIELD_W'(MIN_PHASE);

   generate
      if (MIN_PHASE < 1 || MIN_PHASE >= (1 << FIELD_W)) begin : g_bad_floor
         $error("MIN_PHASE must lie in 1 .. 2**FIELD_W-1");
      end
      if (WORD_W <= 3 * FIELD_W) begin : g_bad_word
         $error("WORD_W must exceed three fields");
      end
   endgenerate

   logic [FIELD_W-1:0] raw   [NUM_FIELDS];
   logic [FIELD_W-1:0] held  [NUM_FIELDS];
   logic               unused_hi_bits;

   // field placement is fixed by the word layout
   assign raw[0] = word_a_i[2*FIELD_W-1:FIELD_W];
   assign raw[1] = word_a_i[FIELD_W-1:0];
   assign raw[2] = word_b_i[FIELD_W-1:0];
   assign raw[3] = word_b_i[2*FIELD_W-1:FIELD_W];
   assign raw[4] = word_b_i[3*FIELD_W-1:2*FIELD_W];

   assign unused_hi_bits = ^{word_a_i[WORD_W-1:2*FIELD_W], word_b_i[WORD_W-1:3*FIELD_W]};

   generate
      for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               held[g] <= FLOOR;
            end else if (capture_i) begin
               held[g] <= (raw[g] < FLOOR) ? FLOOR : raw[g];
            end
         end

         // R8
         floor_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            held[g] >= FLOOR);
      end
   endgenerate

   assign rqst_len_o  = held[0];
   assign exit_len_o  = held[1];
   assign prep_len_o  = held[2];
   assign zero_len_o  = held[3];
   assign trail_len_o = held[4];

endmodule

// File: rtl/dphy_phase_timer.sv
module dphy_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             expired_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= CNT_ONE;
      end else if (restart_i) begin
         cnt_q <= CNT_ONE;
      end else if (cnt_q != CNT_TOP) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign expired_o = (cnt_q >= len_i);

   // R8
   count_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> (cnt_q == CNT_ONE));

endmodule

// File: rtl/dphy_hs_byte_path.sv
module dphy_hs_byte_path #(
   parameter int                 DATA_W    = 8,
   parameter logic [DATA_W-1:0]  SYNC_BYTE = 8'hB8,
   parameter bit                 LSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ld_zero_i,
   input  logic              ld_sync_i,
   input  logic              ld_byte_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              ld_trail_i,
   input  logic              ld_clear_i,
   output logic [DATA_W-1:0] data_o
);

   logic [DATA_W-1:0] data_q;
   logic              wire_last_bit;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign wire_last_bit = data_q[DATA_W-1];
      end else begin : g_msb_first
         assign wire_last_bit = data_q[0];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_q <= '0;
      end else if (ld_clear_i || ld_zero_i) begin
         data_q <= '0;
      end else if (ld_sync_i) begin
         data_q <= SYNC_BYTE;
      end else if (ld_byte_i) begin
         data_q <= byte_i;
      end else if (ld_trail_i) begin
         data_q <= {DATA_W{~wire_last_bit}};
      end
   end

   assign data_o = data_q;

   // R6
   trail_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_trail_i |=> ($countones(data_q) == 0 || $countones(data_q) == DATA_W));

endmodule

// File: rtl/dphy_burst_seq.sv
module dphy_burst_seq
   import dphy_seq_pkg::*;
#(
   parameter int                FIELD_W   = 8,
   parameter int                WORD_W    = 32,
   parameter int                DATA_W    = 8,
   parameter int                MIN_PHASE = 1,
   parameter logic [DATA_W-1:0] SYNC_BYTE = 8'hB8,
   parameter bit                LSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tx_req_i,
   input  logic              tx_valid_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              tx_last_i,
   output logic              tx_ready_o,
   input  logic [WORD_W-1:0] cfg_a_i,
   input  logic [WORD_W-1:0] cfg_b_i,
   output logic              lp_dp_o,
   output logic              lp_dn_o,
   output logic              hs_en_o,
   output logic [DATA_W-1:0] hs_data_o
);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
   endgenerate

   phase_e             phase_q, phase_d;
   logic               expired, accept, capture;
   logic [FIELD_W-1:0] rqst_len, exit_len, prep_len, zero_len, trail_len;
   logic [FIELD_W-1:0] phase_len;
   logic [1:0]         lp_state;

   assign capture = (phase_q == PH_IDLE);

   dphy_timing_capture #(
      .FIELD_W  (FIELD_W),
      .WORD_W   (WORD_W),
      .MIN_PHASE(MIN_PHASE)
   ) u_capture (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .capture_i  (capture),
      .word_a_i   (cfg_a_i),
      .word_b_i   (cfg_b_i),
      .rqst_len_o (rqst_len),
      .exit_len_o (exit_len),
      .prep_len_o (prep_len),
      .zero_len_o (zero_len),
      .trail_len_o(trail_len)
   );

   always_comb begin
      unique case (phase_q)
         PH_RQST:  phase_len = rqst_len;
         PH_BRDG:  phase_len = prep_len;
         PH_ZERO:  phase_len = zero_len;
         PH_TRAIL: phase_len = trail_len;
         PH_EXIT:  phase_len = exit_len;
         default:  phase_len = FIELD_W'(1);
      endcase
   end

   dphy_phase_timer #(
      .CNT_W(FIELD_W)
   ) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(phase_d != phase_q),
      .len_i    (phase_len),
      .expired_o(expired)
   );

   assign tx_ready_o = (phase_q == PH_SYNC) || (phase_q == PH_DATA);
   assign accept     = tx_valid_i && tx_ready_o;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:  if (tx_req_i) phase_d = PH_RQST;
         PH_RQST:  if (expired)  phase_d = PH_BRDG;
         PH_BRDG:  if (expired)  phase_d = PH_ZERO;
         PH_ZERO:  if (expired)  phase_d = PH_SYNC;
         PH_SYNC:  phase_d = (accept && tx_last_i) ? PH_TAIL : PH_DATA;
         PH_DATA:  if (accept && tx_last_i) phase_d = PH_TAIL;
         PH_TAIL:  phase_d = PH_TRAIL;
         PH_TRAIL: if (expired)  phase_d = PH_EXIT;
         PH_EXIT:  if (expired)  phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
      end else begin
         phase_q <= phase_d;
      end
   end

   dphy_hs_byte_path #(
      .DATA_W   (DATA_W),
      .SYNC_BYTE(SYNC_BYTE),
      .LSB_FIRST(LSB_FIRST)
   ) u_bytes (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_zero_i (phase_q == PH_BRDG && phase_d == PH_ZERO),
      .ld_sync_i (phase_q == PH_ZERO && phase_d == PH_SYNC),
      .ld_byte_i (accept),
      .byte_i    (tx_data_i),
      .ld_trail_i(phase_q == PH_TAIL),
      .ld_clear_i(phase_q == PH_TRAIL && phase_d == PH_EXIT),
      .data_o    (hs_data_o)
   );

   always_comb begin
      unique case (phase_q)
         PH_IDLE, PH_EXIT: lp_state = LP_STOP;
         PH_RQST:          lp_state = LP_RQST;
         default:          lp_state = LP_BRDG;
      endcase
   end

   assign lp_dp_o = lp_pos(lp_state);
   assign lp_dn_o = lp_neg(lp_state);
   assign hs_en_o = (phase_q == PH_ZERO) || (phase_q == PH_SYNC) || (phase_q == PH_DATA) ||
                    (phase_q == PH_TAIL) || (phase_q == PH_TRAIL);

   // R3
   lp_no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lp_dp_o && lp_dn_o) |=> !(!lp_dp_o && !lp_dn_o));

   // R3
   hs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_en_o) |-> (!$past(lp_dp_o) && !$past(lp_dn_o) && hs_data_o == '0));

   // R4
   sync_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tx_ready_o) |-> (hs_en_o && hs_data_o == SYNC_BYTE));

   // R7
   exit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(hs_en_o) |-> (lp_dp_o && lp_dn_o && !tx_ready_o && hs_data_o == '0));

   // R5
   ready_in_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_ready_o |-> hs_en_o);

endmodule

// File: tb/dphy_burst_seq_test.sv
module dphy_burst_seq_test;

   typedef struct packed {
      logic [1:0] lp;
      logic       hs;
      logic [7:0] d;
      logic       rdy;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_req = 1'b0, tx_valid = 1'b0, tx_last = 1'b0;
   logic [7:0]  tx_data = 8'h00;
   logic [31:0] cfg_a = 32'h0, cfg_b = 32'h0;
   logic        tx_ready, lp_dp, lp_dn, hs_en;
   logic [7:0]  hs_data;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   logic       drv_v[$];
   logic [7:0] drv_d[$];

   always #5 clk = ~clk;

   dphy_burst_seq uut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tx_req_i  (tx_req),
      .tx_valid_i(tx_valid),
      .tx_data_i (tx_data),
      .tx_last_i (tx_last),
      .tx_ready_o(tx_ready),
      .cfg_a_i   (cfg_a),
      .cfg_b_i   (cfg_b),
      .lp_dp_o   (lp_dp),
      .lp_dn_o   (lp_dn),
      .hs_en_o   (hs_en),
      .hs_data_o (hs_data)
   );

   function automatic int fld(input logic [31:0] w, input int k);
      logic [7:0] f = w[k*8 +: 8];
      return (f == 8'h00) ? 1 : int'(f);
   endfunction

   task automatic compare(input exp_t e, input string tag, input int cyc);
      checks++;
      if ({lp_dp, lp_dn} !== e.lp || hs_en !== e.hs || hs_data !== e.d || tx_ready !== e.rdy) begin
         fails++;
         $display("FAIL %s cycle %0d: actual lp=%b hs_en=%b data=%h rdy=%b expected lp=%b hs_en=%b data=%h rdy=%b",
                  tag, cyc, {lp_dp, lp_dn}, hs_en, hs_data, tx_ready, e.lp, e.hs, e.d, e.rdy);
      end
   endtask

   task automatic run_burst(input logic [31:0] wa, input logic [31:0] wb,
                            input bit hold_req, input bit alt_cfg, input string tag);
      exp_t  q[$];
      string tq[$];
      int tl, xp, pr, zr, tr, sync_at, n;
      logic [7:0] cur, inv;
      tl = fld(wa, 1); xp = fld(wa, 0);
      pr = fld(wb, 0); zr = fld(wb, 1); tr = fld(wb, 2);
      for (int i = 0; i < tl; i++) begin q.push_back('{2'b01, 1'b0, 8'h00, 1'b0}); tq.push_back({"R3 ", tag}); end
      for (int i = 0; i < pr; i++) begin q.push_back('{2'b00, 1'b0, 8'h00, 1'b0}); tq.push_back({"R3 ", tag}); end
      for (int i = 0; i < zr; i++) begin q.push_back('{2'b00, 1'b1, 8'h00, 1'b0}); tq.push_back({"R3 ", tag}); end
      sync_at = q.size();
      q.push_back('{2'b00, 1'b1, 8'hB8, 1'b1}); tq.push_back({"R4 ", tag});
      cur = 8'hB8;
      n = drv_v.size();
      for (int j = 0; j < n; j++) begin
         if (drv_v[j]) cur = drv_d[j];
         q.push_back('{2'b00, 1'b1, cur, (j == n - 1) ? 1'b0 : 1'b1});
         tq.push_back({"R5 ", tag});
      end
      inv = {8{~cur[7]}};
      for (int i = 0; i < tr; i++) begin q.push_back('{2'b00, 1'b1, inv, 1'b0}); tq.push_back({"R6 ", tag}); end
      for (int i = 0; i < xp; i++) begin q.push_back('{2'b11, 1'b0, 8'h00, 1'b0}); tq.push_back({"R7 ", tag}); end

      @(negedge clk);
      compare('{2'b11, 1'b0, 8'h00, 1'b0}, {"R7 idle ", tag}, -1);
      cfg_a = wa; cfg_b = wb; tx_req = 1'b1;
      for (int k = 0; k < q.size(); k++) begin
         @(negedge clk);
         compare(q[k], tq[k], k);
         if (k == 0 && !hold_req) tx_req = 1'b0;
         if (k == 0 && alt_cfg) begin cfg_a = 32'h0000_0909; cfg_b = 32'h0009_0909; end
         if (k >= sync_at && k - sync_at < n) begin
            tx_valid = drv_v[k - sync_at];
            tx_data  = drv_d[k - sync_at];
            tx_last  = (k - sync_at == n - 1);
         end else begin
            tx_valid = 1'b0; tx_data = 8'h00; tx_last = 1'b0;
         end
      end
      if (!hold_req) tx_req = 1'b0;
   endtask

   task automatic set_payload(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2, input int cnt);
      drv_v.delete(); drv_d.delete();
      if (cnt > 0) begin drv_v.push_back(1'b1); drv_d.push_back(b0); end
      if (cnt > 1) begin drv_v.push_back(1'b1); drv_d.push_back(b1); end
      if (cnt > 2) begin drv_v.push_back(1'b1); drv_d.push_back(b2); end
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=still running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state, held in reset and just after release
      compare('{2'b11, 1'b0, 8'h00, 1'b0}, "R1 in reset", -1);
      rst_n = 1'b1;
      @(negedge clk);
      compare('{2'b11, 1'b0, 8'h00, 1'b0}, "R1 after release", -1);

      // R3 R4 R5 R6 R7 nominal timing, three bytes, last bit 0 -> trailer 0xFF
      set_payload(8'h12, 8'hA5, 8'h3C, 3);
      run_burst(32'h0000_0306, 32'h0004_0A03, 1'b0, 1'b0, "nominal");

      // R2 upper bits set must not matter; single byte with bit7=1 -> trailer 0x00
      set_payload(8'h81, 8'h00, 8'h00, 1);
      run_burst(32'hFFFF_0203, 32'hCD02_0305, 1'b0, 1'b0, "R2 upper bits");

      // R8 every field zero -> one cycle per phase
      set_payload(8'h7E, 8'hFF, 8'h00, 2);
      run_burst(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, "R8 zero fields");

      // R9 timing words changed right after the request is taken
      set_payload(8'h40, 8'hC0, 8'h01, 3);
      run_burst(32'h0000_0204, 32'h0003_0502, 1'b0, 1'b1, "R9 cfg change");

      // R10 request held through the burst, then R7 back-to-back start waits for exit
      set_payload(8'h55, 8'hAA, 8'h00, 2);
      run_burst(32'h0000_0105, 32'h0002_0401, 1'b1, 1'b0, "R10 held req");
      set_payload(8'h0F, 8'h00, 8'h00, 1);
      run_burst(32'h0000_0402, 32'h0001_0201, 1'b0, 1'b0, "R7 back to back");

      // R11 gaps in the payload stream repeat the previous byte
      drv_v.delete(); drv_d.delete();
      drv_v.push_back(1'b0); drv_d.push_back(8'hEE);
      drv_v.push_back(1'b1); drv_d.push_back(8'h24);
      drv_v.push_back(1'b0); drv_d.push_back(8'h99);
      drv_v.push_back(1'b0); drv_d.push_back(8'h98);
      drv_v.push_back(1'b1); drv_d.push_back(8'hE7);
      run_burst(32'h0000_0203, 32'h0003_0302, 1'b0, 1'b0, "R11 stalls");

      // long zero phase with R3 margin values
      set_payload(8'h11, 8'h22, 8'h33, 3);
      run_burst(32'h0000_0306, 32'h0004_0C03, 1'b0, 1'b0, "R3 long zero");

      repeat (4) begin
         @(negedge clk);
         compare('{2'b11, 1'b0, 8'h00, 1'b0}, "R7 final idle", -1);
      end
      finish_run();
   end

endmodule